// File: doc/BRIEF.md
# PWM Time-Base Counter with Chained Synchronization

This block is the time-base stage of a pulse-width modulator channel. It divides the module clock into a time-base tick using a programmable prescale. On every tick it advances a period counter, either counting up and wrapping, or counting up and down in a triangle. Comparators, waveform qualifiers and dead-band stages downstream read the counter value and the count direction.

Several instances can be locked to one master. The master emits a one-clock sync pulse when its counter steps to zero, when it steps onto a compare-D value, or on both. A follower that has phase loading enabled captures the rising edge of its sync input and holds it as a pending request. On the next valid tick it loads its programmed phase value and, in up/down mode, a programmed direction. Because the request is registered first, the follower trails the master by a fixed amount: two module clocks when no prescale is used, and exactly one tick otherwise, in either count mode. A second way to align instances is to clear all counters and release a shared tick enable, so that they start counting together.

Configuration is written through a small register port with four word addresses.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the counter is 0, the direction output is 1 (up), sync out is 0, and every configuration register holds 0.
- R2: A write with `cfg_we_i` high stores `cfg_wdata_i` at address 0 (control), 1 (period), 2 (phase) or 3 (compare-D). The control fields are: bit 0 selects the mode (0 up, 1 up/down), bit 1 enables phase loading, bit 2 gives the direction after sync (1 up, 0 down), bit 3 enables sync out on zero, bit 4 enables sync out on compare-D, and bits 7:5 hold the prescale `p`.
- R3: While `tick_en_i` is high, a tick occurs once every `p+1` module clocks. The first tick falls in clock `p`, counting from 0 at the first enabled clock. The counter changes only on ticks. While `tick_en_i` is low the counter holds its value and the prescaler returns to 0.
- R4: In up mode the counter runs 0,1,…,period and then back to 0, and the direction output stays 1.
- R5: In up/down mode the counter climbs to the period and then descends to 0. The direction output reads 1 from the step that leaves 0 until the step that reaches the period, and 0 from the step that leaves the period until the step that reaches 0. With a period of 0 the counter stays at 0.
- R6: When phase loading is enabled, a rising edge on `sync_i` sets a pending load. The phase value enters the counter on the first tick in a later clock than the edge, never in the edge's own clock.
- R7: For a follower chained to a master with the same prescale and period, the follower's counter equals the master's counter from a fixed number of clocks earlier. That lag is 2 clocks for prescale 0 and `p+1` clocks (one tick) otherwise, in both modes and for both after-sync direction settings.
- R8: With phase loading disabled, `sync_i` has no effect on the counter.
- R9: Further sync edges that arrive while a load is pending merge into that single load.
- R10: On a sync load in up/down mode the direction becomes the after-sync direction bit. In up mode it stays up.
- R11: A sync load of phase 0 with after-sync direction down forces the direction to up, so the next tick gives 1.
- R12: With sync-on-zero enabled, `sync_o` is high for the one clock that follows a tick on which the counter stepped from a non-zero value to 0. A phase load does not cause this pulse.
- R13: With sync-on-compare-D enabled, `sync_o` pulses for one clock after each step onto the compare-D value, on both the up slope and the down slope.
- R14: Two instances with the same configuration, reset together and released by the same tick enable, produce identical counter values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Global tick enable shared by all instances |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration word address |
| cfg_wdata_i | input | CNT_W | Configuration write data |
| sync_i | input | 1 | Synchronization input from an upstream instance |
| sync_o | output | 1 | One-clock synchronization pulse to downstream instances |
| cnt_o | output | CNT_W | Time-base counter value |
| dir_up_o | output | 1 | Count direction, 1 for up |

## Verification
The bench sweeps several prescales in both modes and compares the counter and direction at every clock against the expected tick count. It chains a follower to a master for every prescale, mode and after-sync direction and compares the follower against a delayed copy of the master. This catches a design that applies the phase in the edge clock (lag too short), adds an extra stage (lag too long), or lets up/down mode change the lag. Directed cases place a sync edge exactly on a tick clock, send two edges into one pending window, pulse sync with phase loading off, and load phase 0 with direction down; each of these would show a wrong counter one tick later if handled incorrectly. Compare-D pulses are counted on both slopes, so a comparator that only fires on one slope loses half of them.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;

  localparam int PSC_W = 3;

  typedef enum logic {
    MODE_UP   = 1'b0,
    MODE_UPDN = 1'b1
  } cnt_mode_e;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic             so_cmpd_en;
    logic             so_zero_en;
    logic             dir_after_up;
    logic             phase_en;
    cnt_mode_e        mode;
  } tb_ctrl_t;

  localparam int CTRL_W = $bits(tb_ctrl_t);

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PERIOD = 2'd1,
    REG_PHASE  = 2'd2,
    REG_CMPD   = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);

  logic [PSC_W-1:0] div_q;

  // >= keeps the divider sane if the prescale is lowered mid-run
  assign tick_o = en_i && (div_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (!en_i)   div_q <= '0;
    else if (tick_o)  div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/pwm_sync_capture.sv
module pwm_sync_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic phase_en_i,
  input  logic tick_i,
  output logic load_o
);

  logic sync_q, pend_q, pend_d, rise;

  assign rise   = sync_i && !sync_q;
  assign load_o = pend_q && tick_i;

  // edges seen while a load is pending fold into it
  always_comb begin
    if (!phase_en_i)  pend_d = 1'b0;
    else if (pend_q)  pend_d = !tick_i;
    else              pend_d = rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sync_q <= sync_i;
      pend_q <= pend_d;
    end
  end

  AST_PEND_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && tick_i) |=> !pend_q); // R9

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  cnt_mode_e        mode_i,
  input  logic             dir_after_up_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [CNT_W-1:0] cmpd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_up_o,
  output logic             zero_evt_o,
  output logic             cmpd_evt_o
);

  logic [CNT_W-1:0] cnt_q, step_cnt, nxt_cnt;
  logic             dir_q, step_dir, nxt_dir;

  always_comb begin
    step_cnt = cnt_q;
    step_dir = dir_q;
    if (period_i == '0) begin
      step_cnt = '0;
      step_dir = 1'b1;
    end else if (mode_i == MODE_UP) begin
      step_dir = 1'b1;
      step_cnt = (cnt_q >= period_i) ? '0 : cnt_q + 1'b1;
    end else if (dir_q) begin
      if (cnt_q >= period_i) begin
        step_dir = 1'b0;
        step_cnt = cnt_q - 1'b1;
      end else begin
        step_cnt = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        step_dir = 1'b1;
        step_cnt = {{(CNT_W-1){1'b0}}, 1'b1};
      end else begin
        step_cnt = cnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    if (load_i) begin
      nxt_cnt = phase_i;
      // down-count from a zero phase is not allowed
      nxt_dir = (mode_i == MODE_UP) || dir_after_up_i || (phase_i == '0);
    end else begin
      nxt_cnt = step_cnt;
      nxt_dir = step_dir;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= nxt_cnt;
      dir_q <= nxt_dir;
    end
  end

  assign zero_evt_o = tick_i && !load_i && (step_cnt == '0) && (cnt_q != '0);
  assign cmpd_evt_o = tick_i && !load_i && (step_cnt == cmpd_i) && (cnt_q != cmpd_i);
  assign cnt_o      = cnt_q;
  assign dir_up_o   = dir_q;

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(cnt_q)); // R3

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [CNT_W-1:0] cfg_wdata_i,
  input  logic             sync_i,
  output logic             sync_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_up_o
);

  tb_ctrl_t         ctrl_q;
  logic [CNT_W-1:0] period_q, phase_q, cmpd_q;
  logic             tick, load, zero_evt, cmpd_evt, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      period_q <= '0;
      phase_q  <= '0;
      cmpd_q   <= '0;
    end else if (cfg_we_i) begin
      unique case (reg_addr_e'(cfg_addr_i))
        REG_CTRL:   ctrl_q   <= tb_ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
        REG_PERIOD: period_q <= cfg_wdata_i;
        REG_PHASE:  phase_q  <= cfg_wdata_i;
        REG_CMPD:   cmpd_q   <= cfg_wdata_i;
        default:    ;
      endcase
    end
  end

  pwm_tick_gen #(.PSC_W(PSC_W)) i_tick_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en_i),
    .psc_i  (ctrl_q.psc),
    .tick_o (tick)
  );

  pwm_sync_capture i_sync_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .phase_en_i (ctrl_q.phase_en),
    .tick_i     (tick),
    .load_o     (load)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tick_i         (tick),
    .load_i         (load),
    .mode_i         (ctrl_q.mode),
    .dir_after_up_i (ctrl_q.dir_after_up),
    .period_i       (period_q),
    .phase_i        (phase_q),
    .cmpd_i         (cmpd_q),
    .cnt_o          (cnt_o),
    .dir_up_o       (dir_up_o),
    .zero_evt_o     (zero_evt),
    .cmpd_evt_o     (cmpd_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else         sync_q <= (zero_evt && ctrl_q.so_zero_en) || (cmpd_evt && ctrl_q.so_cmpd_en);
  end

  assign sync_o = sync_q;

  AST_SYNC_OUT_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q |-> $past(tick)); // R12

  AST_LOAD_TAKES_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (cnt_o == $past(phase_q))); // R6

  AST_NO_LOAD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.phase_en |-> !load); // R8

endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ten_m = 1'b0, ten_s = 1'b0;
  logic        m_we = 1'b0, s_we = 1'b0;
  logic [1:0]  m_addr = '0, s_addr = '0;
  logic [15:0] m_wdata = '0, s_wdata = '0;
  logic        sync_drv = 1'b0, use_chain = 1'b0;
  logic        m_so, s_so, m_dir, s_dir, s_sync;
  logic [15:0] m_cnt, s_cnt;
  int          n_chk = 0, n_bad = 0, jc = 0;

  always #4ns clk = ~clk;

  assign s_sync = use_chain ? m_so : sync_drv;

  pwm_timebase #(.CNT_W(16)) i_master (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(ten_m), .cfg_we_i(m_we),
    .cfg_addr_i(m_addr), .cfg_wdata_i(m_wdata), .sync_i(1'b0),
    .sync_o(m_so), .cnt_o(m_cnt), .dir_up_o(m_dir));

  pwm_timebase #(.CNT_W(16)) i_pwm_timebase (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(ten_s), .cfg_we_i(s_we),
    .cfg_addr_i(s_addr), .cfg_wdata_i(s_wdata), .sync_i(s_sync),
    .sync_o(s_so), .cnt_o(s_cnt), .dir_up_o(s_dir));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_ctrl(input bit mode, input bit pe, input bit dir,
                                          input bit ze, input bit ce, input int psc);
    logic [2:0] p;
    p = psc[2:0];
    return {8'h00, p, ce, ze, dir, pe, mode};
  endfunction

  task automatic wr(input bit to_s, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    if (to_s) begin s_we = 1'b1; s_addr = a; s_wdata = d; end
    else      begin m_we = 1'b1; m_addr = a; m_wdata = d; end
    @(negedge clk);
    s_we = 1'b0;
    m_we = 1'b0;
  endtask

  task automatic rst_all();
    ten_m = 1'b0; ten_s = 1'b0; sync_drv = 1'b0; use_chain = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic adv_to(input int target);
    while (jc < target) begin
      @(negedge clk);
      jc++;
    end
  endtask

  initial begin
    #1ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pl[3];
    int d, e, p, n, t, v, cnt_p, lag;
    int hist[9];
    bit modes[3];
    bit dirs[3];
    bit cm[4];
    bit cdir[4];
    int cph[4], cexd[4], cnx[4];

    // R1 reset state
    rst_all();
    chk("R1 cnt", int'(s_cnt), 0);
    chk("R1 dir", int'(s_dir), 1);
    chk("R1 sync_o", int'(s_so), 0);
    ten_s = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 period reg zero holds cnt", int'(s_cnt), 0);

    // R2 R3 R4 R12 R14: up mode sweep, both instances released together
    pl = '{0, 1, 3};
    for (int pi = 0; pi < 3; pi++) begin
      d = pl[pi] + 1;
      rst_all();
      wr(0, 2'd0, mk_ctrl(0, 0, 0, 1, 0, pl[pi])); wr(0, 2'd1, 16'd5);
      wr(1, 2'd0, mk_ctrl(0, 0, 0, 1, 0, pl[pi])); wr(1, 2'd1, 16'd5);
      ten_m = 1'b1; ten_s = 1'b1;
      for (int j = 1; j <= 18 * d; j++) begin
        @(negedge clk);
        e = (j / d) % 6;
        p = ((j - 1) / d) % 6;
        chk("R4 up count", int'(m_cnt), e);
        chk("R14 aligned start", int'(s_cnt), e);
        chk("R4 up dir", int'(m_dir), 1);
        chk("R12 zero pulse", int'(m_so), (e == 0 && p != 0) ? 1 : 0);
      end
      ten_m = 1'b0;
      v = int'(m_cnt);
      repeat (3 * d + 5) @(negedge clk);
      chk("R3 freeze", int'(m_cnt), v);
    end

    // R5 up/down sweep
    pl = '{0, 2, 1};
    for (int pi = 0; pi < 2; pi++) begin
      d = pl[pi] + 1;
      rst_all();
      wr(0, 2'd0, mk_ctrl(1, 0, 1, 0, 0, pl[pi])); wr(0, 2'd1, 16'd4);
      ten_m = 1'b1;
      for (int j = 1; j <= 24 * d; j++) begin
        @(negedge clk);
        n = j / d;
        t = n % 8;
        e = (t <= 4) ? t : 8 - t;
        chk("R5 updown count", int'(m_cnt), e);
        chk("R5 updown dir", int'(m_dir), (n == 0 || (t >= 1 && t <= 4)) ? 1 : 0);
      end
    end
    rst_all();
    wr(0, 2'd0, mk_ctrl(1, 0, 1, 0, 0, 0));
    ten_m = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5 period zero", int'(m_cnt), 0);

    // R13 compare-D pulses on both slopes
    rst_all();
    wr(0, 2'd0, mk_ctrl(1, 0, 1, 0, 1, 0)); wr(0, 2'd1, 16'd4); wr(0, 2'd3, 16'd2);
    ten_m = 1'b1;
    cnt_p = 0;
    for (int j = 1; j <= 32; j++) begin
      @(negedge clk);
      t = j % 8;
      e = (t <= 4) ? t : 8 - t;
      t = (j - 1) % 8;
      p = (t <= 4) ? t : 8 - t;
      chk("R13 cmpd pulse", int'(m_so), (e == 2 && p != 2) ? 1 : 0);
      if (m_so) cnt_p++;
    end
    chk("R13 pulses both slopes", cnt_p, 8);

    // R8 sync ignored with phase loading off
    rst_all();
    wr(1, 2'd0, mk_ctrl(0, 0, 1, 0, 0, 1)); wr(1, 2'd1, 16'd9); wr(1, 2'd2, 16'd3);
    ten_s = 1'b1;
    for (int j = 1; j <= 30; j++) begin
      @(negedge clk);
      sync_drv = (j == 4 || j == 11);
      chk("R8 sync ignored", int'(s_cnt), (j / 2) % 10);
    end

    // R6 load on next tick, prescale 3
    rst_all();
    wr(1, 2'd0, mk_ctrl(0, 1, 1, 0, 0, 3)); wr(1, 2'd1, 16'd30); wr(1, 2'd2, 16'd20);
    ten_s = 1'b1; jc = 0;
    adv_to(5); sync_drv = 1'b1;
    adv_to(6); sync_drv = 1'b0;
    adv_to(7);  chk("R6 not before tick", int'(s_cnt), 1);
    adv_to(8);  chk("R6 phase loaded", int'(s_cnt), 20);
    adv_to(12); chk("R6 counts on", int'(s_cnt), 21);

    // R6 edge in a tick clock waits for the following tick
    rst_all();
    wr(1, 2'd0, mk_ctrl(0, 1, 1, 0, 0, 3)); wr(1, 2'd1, 16'd30); wr(1, 2'd2, 16'd20);
    ten_s = 1'b1; jc = 0;
    adv_to(7); sync_drv = 1'b1;
    adv_to(8); sync_drv = 1'b0;
    chk("R6 same-clock edge not applied", int'(s_cnt), 2);
    adv_to(11); chk("R6 held until tick", int'(s_cnt), 2);
    adv_to(12); chk("R6 late load", int'(s_cnt), 20);

    // R9 merge of edges in one pending window
    rst_all();
    wr(1, 2'd0, mk_ctrl(0, 1, 1, 0, 0, 7)); wr(1, 2'd1, 16'd30); wr(1, 2'd2, 16'd10);
    ten_s = 1'b1; jc = 0;
    adv_to(1); sync_drv = 1'b1;
    adv_to(2); sync_drv = 1'b0;
    adv_to(3); sync_drv = 1'b1;
    adv_to(4); sync_drv = 1'b0;
    adv_to(8);  chk("R9 single load", int'(s_cnt), 10);
    adv_to(16); chk("R9 no second load", int'(s_cnt), 11);
    adv_to(24); chk("R9 keeps counting", int'(s_cnt), 12);

    // R10 R11 direction after sync
    cm   = '{1, 1, 1, 0};
    cdir = '{0, 1, 0, 0};
    cph  = '{5, 5, 0, 5};
    cexd = '{0, 1, 1, 1};
    cnx  = '{4, 6, 1, 6};
    for (int c = 0; c < 4; c++) begin
      rst_all();
      wr(1, 2'd0, mk_ctrl(cm[c], 1, cdir[c], 0, 0, 0)); wr(1, 2'd1, 16'd10);
      wr(1, 2'd2, 16'(cph[c]));
      ten_s = 1'b1; jc = 0;
      adv_to(3); sync_drv = 1'b1;
      adv_to(4); sync_drv = 1'b0;
      adv_to(5);
      chk("R10 loaded value", int'(s_cnt), cph[c]);
      if (c == 2) chk("R11 forced up", int'(s_dir), cexd[c]);
      else        chk("R10 dir after sync", int'(s_dir), cexd[c]);
      adv_to(6);
      if (c == 2) chk("R11 next step", int'(s_cnt), cnx[c]);
      else        chk("R10 next step", int'(s_cnt), cnx[c]);
    end

    // R7 chained lag across prescale, mode and direction bit
    modes = '{0, 1, 1};
    dirs  = '{1, 1, 0};
    pl = '{0, 1, 3};
    for (int mi = 0; mi < 3; mi++) begin
      for (int pi = 0; pi < 3; pi++) begin
        d = pl[pi] + 1;
        lag = (d == 1) ? 2 : d;
        rst_all();
        wr(0, 2'd0, mk_ctrl(modes[mi], 0, 1, 1, 0, pl[pi])); wr(0, 2'd1, 16'd6);
        wr(1, 2'd0, mk_ctrl(modes[mi], 1, dirs[mi], 0, 0, pl[pi])); wr(1, 2'd1, 16'd6);
        wr(1, 2'd2, 16'd0);
        use_chain = 1'b1;
        ten_s = 1'b1;
        repeat (3 * d) @(negedge clk);
        ten_m = 1'b1;
        repeat (16 * d + 4) @(negedge clk);
        for (int k = 0; k < 9; k++) hist[k] = 0;
        for (int k = 0; k < 9; k++) begin
          @(negedge clk);
          for (int h = 8; h > 0; h--) hist[h] = hist[h-1];
          hist[0] = int'(m_cnt);
        end
        for (int j = 0; j < 28 * d; j++) begin
          @(negedge clk);
          for (int h = 8; h > 0; h--) hist[h] = hist[h-1];
          hist[0] = int'(m_cnt);
          chk("R7 follower lag", int'(s_cnt), hist[lag]);
        end
      end
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule